// File: doc/BRIEF.md
# Pixel Point ALU With Shifter

This block is a per-pixel preprocessing stage that sits in front of a convolution datapath. Each clock it takes one 8-bit pixel, holds it in a short programmable delay line of one to four stages, combines the delayed pixel with an 8-bit constant using one of nineteen logical or arithmetic functions, and then shifts the 8-bit result left or right by up to three places. The result leaves through a register.

A 10-bit microcode word sets the behaviour. Its upper three bits choose the shift and its lower seven bits choose the function. The two fields are decoded separately, so any function can be paired with any shift. The microcode, the constant and the delay setting are written through a small register-write port. That port takes a write enable, a 2-bit address and a 10-bit data word. Delays longer than one stage let several such stages line up their pixel streams.

Top module: `pix_alu_shift`

## Requirements
- R1: The delay register (address 2, data bits 1:0 holding code d) sets an input delay of N = d+1 clocks. A pixel on `pix_in` at a rising edge first shows up, processed, on `pix_out` after N+1 rising edges.
- R2: A write with `cfg_we`=1 to address 1 loads data bits 7:0 into the constant (operand B). With `cfg_we`=0, `cfg_addr` and `cfg_data` have no effect.
- R3: A write to address 0 loads the full 10-bit microcode. Bits 9:7 are the shift field and bits 6:0 are the function code. The two fields act independently of each other.
- R4: Function codes, with A the delayed pixel and B the constant: 0 A, 1 all zeros, 2 all ones, 3 B, 4 ~A, 5 ~B, 6 A+B, 7 A-B, 8 B-A, 9 A&B, 10 A|B, 11 A^B, 12 ~(A&B), 13 ~(A|B), 14 ~(A^B), 15 A&~B, 16 ~A&B, 17 A|~B, 18 ~A|B.
- R5: Arithmetic results wrap modulo 256 before the shift.
- R6: Shift codes 1, 2 and 3 shift right by 1, 2 and 3 places, with zeros entering at the top. Code 0 applies no shift.
- R7: Shift codes 4, 5 and 6 shift left by 1, 2 and 3 places. Zeros enter at the bottom, and bits pushed past bit 7 are lost.
- R8: Shift code 7 behaves as no shift.
- R9: Function codes 19 to 127 behave as code 0 (pass A).
- R10: Synchronous active-high `rst` clears the microcode (pass A, no shift), the constant, the delay code (one-clock delay), every delay stage and `pix_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 8 | Incoming pixel, one per clock |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Register select: 0 microcode, 1 constant, 2 delay |
| cfg_data | input | 10 | Configuration write data |
| pix_out | output | 8 | Registered processed pixel |

## Verification
The hardest thing to observe from the ports is the delay line. Any single held pixel value gives the same output at every delay setting, so a wrong tap would go unnoticed. For each of the four delay codes, the bench therefore drives a stream of pixels that changes every clock. It keeps a history of that stream and compares `pix_out` with the pixel sent exactly N+1 clocks earlier. Left-shift overflow and wrap-around arithmetic are reached through table entries whose operands are chosen to carry out of bit 7.

// File: rtl/pix_alu_pkg.sv
package pix_alu_pkg;

    localparam int PIX_W     = 8;
    localparam int OP_W      = 7;
    localparam int SH_W      = 3;
    localparam int MC_W      = OP_W + SH_W;
    localparam int MAX_DLY   = 4;
    localparam int DSEL_W    = $clog2(MAX_DLY);
    localparam int CFG_A_W   = 2;

    localparam logic [CFG_A_W-1:0] ADDR_MCODE = 2'd0;
    localparam logic [CFG_A_W-1:0] ADDR_CONST = 2'd1;
    localparam logic [CFG_A_W-1:0] ADDR_DELAY = 2'd2;

    typedef enum logic [OP_W-1:0] {
        OP_PASS_A  = 7'd0,
        OP_ZERO    = 7'd1,
        OP_ONES    = 7'd2,
        OP_PASS_B  = 7'd3,
        OP_NOT_A   = 7'd4,
        OP_NOT_B   = 7'd5,
        OP_ADD     = 7'd6,
        OP_A_MIN_B = 7'd7,
        OP_B_MIN_A = 7'd8,
        OP_AND     = 7'd9,
        OP_OR      = 7'd10,
        OP_XOR     = 7'd11,
        OP_NAND    = 7'd12,
        OP_NOR     = 7'd13,
        OP_XNOR    = 7'd14,
        OP_A_ANDN  = 7'd15,
        OP_NA_AND  = 7'd16,
        OP_A_ORN   = 7'd17,
        OP_NA_OR   = 7'd18
    } alu_op_e;

    typedef enum logic [SH_W-1:0] {
        SH_NONE = 3'd0,
        SH_R1   = 3'd1,
        SH_R2   = 3'd2,
        SH_R3   = 3'd3,
        SH_L1   = 3'd4,
        SH_L2   = 3'd5,
        SH_L3   = 3'd6,
        SH_BAD  = 3'd7
    } shift_e;

    typedef struct packed {
        logic [SH_W-1:0] shift;
        logic [OP_W-1:0] op;
    } mcode_t;

    function automatic logic is_right(input logic [SH_W-1:0] s);
        return (s == SH_R1) || (s == SH_R2) || (s == SH_R3);
    endfunction

    function automatic logic is_left(input logic [SH_W-1:0] s);
        return (s == SH_L1) || (s == SH_L2) || (s == SH_L3);
    endfunction

endpackage

// File: rtl/pix_delay.sv
module pix_delay #(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    localparam int SW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    input  logic [SW-1:0] sel,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] stage [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= din;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[g] <= '0;
            else     stage[g] <= stage[g-1];
        end

        a_r1_chain_step: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> stage[g] == $past(stage[g-1]));
    end

    assign dout = stage[sel];

    a_r1_first_stage: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stage[0] == $past(din));

endmodule

// File: rtl/pix_alu_core.sv
module pix_alu_core
    import pix_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic [OP_W-1:0] op,
    output logic [DW-1:0]   res
);

    always_comb begin
        case (op)
            OP_ZERO:    res = '0;
            OP_ONES:    res = '1;
            OP_PASS_B:  res = b;
            OP_NOT_A:   res = ~a;
            OP_NOT_B:   res = ~b;
            OP_ADD:     res = a + b;
            OP_A_MIN_B: res = a - b;
            OP_B_MIN_A: res = b - a;
            OP_AND:     res = a & b;
            OP_OR:      res = a | b;
            OP_XOR:     res = a ^ b;
            OP_NAND:    res = ~(a & b);
            OP_NOR:     res = ~(a | b);
            OP_XNOR:    res = ~(a ^ b);
            OP_A_ANDN:  res = a & ~b;
            OP_NA_AND:  res = ~a & b;
            OP_A_ORN:   res = a | ~b;
            OP_NA_OR:   res = ~a | b;
            default:    res = a;
        endcase
    end

endmodule

// File: rtl/pix_shift.sv
module pix_shift
    import pix_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0]   din,
    input  logic [SH_W-1:0] code,
    output logic [DW-1:0]   dout
);

    always_comb begin
        case (code)
            SH_R1:   dout = din >> 1;
            SH_R2:   dout = din >> 2;
            SH_R3:   dout = din >> 3;
            SH_L1:   dout = din << 1;
            SH_L2:   dout = din << 2;
            SH_L3:   dout = din << 3;
            default: dout = din;
        endcase
    end

endmodule

// File: rtl/pix_alu_shift.sv
module pix_alu_shift
    import pix_alu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [PIX_W-1:0]   pix_in,
    input  logic               cfg_we,
    input  logic [CFG_A_W-1:0] cfg_addr,
    input  logic [MC_W-1:0]    cfg_data,
    output logic [PIX_W-1:0]   pix_out
);

    mcode_t              mcode_q;
    logic [PIX_W-1:0]    const_q;
    logic [DSEL_W-1:0]   dly_q;
    logic [PIX_W-1:0]    pix_dly;
    logic [PIX_W-1:0]    alu_res;
    logic [PIX_W-1:0]    shf_res;
    logic [PIX_W-1:0]    out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mcode_q <= '{shift: SH_NONE, op: OP_PASS_A};
            const_q <= '0;
            dly_q   <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                ADDR_MCODE: mcode_q <= mcode_t'(cfg_data);
                ADDR_CONST: const_q <= cfg_data[PIX_W-1:0];
                ADDR_DELAY: dly_q   <= cfg_data[DSEL_W-1:0];
                default:    ;
            endcase
        end
    end

    pix_delay #(.DW(PIX_W), .DEPTH(MAX_DLY)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (pix_in),
        .sel  (dly_q),
        .dout (pix_dly)
    );

    pix_alu_core #(.DW(PIX_W)) u_alu (
        .a   (pix_dly),
        .b   (const_q),
        .op  (mcode_q.op),
        .res (alu_res)
    );

    pix_shift #(.DW(PIX_W)) u_shf (
        .din  (alu_res),
        .code (mcode_q.shift),
        .dout (shf_res)
    );

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= shf_res;
    end

    assign pix_out = out_q;

    a_r3_mcode_load: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == ADDR_MCODE) |=> mcode_q == $past(cfg_data));

    a_r2_const_load: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == ADDR_CONST) |=> const_q == $past(cfg_data[PIX_W-1:0]));

    a_r2_const_hold: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && cfg_addr == ADDR_CONST) |=> $stable(const_q));

    a_r10_reset_defaults: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mcode_q == '0 && const_q == '0 && dly_q == '0 && pix_out == '0));

    a_r6_right_zero_fill: assert property (@(posedge clk) disable iff (rst)
        is_right(mcode_q.shift) |-> shf_res[PIX_W-1] == 1'b0);

    a_r7_left_zero_lsb: assert property (@(posedge clk) disable iff (rst)
        is_left(mcode_q.shift) |-> shf_res[0] == 1'b0);

    a_r8_invalid_passes: assert property (@(posedge clk) disable iff (rst)
        (mcode_q.shift == SH_BAD) |-> shf_res == alu_res);

    a_r1_output_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pix_out == $past(shf_res));

endmodule

// File: tb/pix_alu_shift_tb.sv
module pix_alu_shift_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pix_in = '0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [9:0] cfg_data = '0;
    logic [7:0] pix_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pix_alu_shift u_dut (
        .clk      (clk),
        .rst      (rst),
        .pix_in   (pix_in),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .pix_out  (pix_out)
    );

    // {shift, op, B, A, expected}
    typedef struct packed {
        logic [2:0] sh;
        logic [6:0] op;
        logic [7:0] b;
        logic [7:0] a;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 7'd0,  8'h00, 8'h5A, 8'h5A, 4'd4},
        '{3'd0, 7'd1,  8'h00, 8'hFF, 8'h00, 4'd4},
        '{3'd1, 7'd2,  8'h00, 8'h00, 8'h7F, 4'd6},
        '{3'd4, 7'd3,  8'hC3, 8'h00, 8'h86, 4'd7},
        '{3'd0, 7'd4,  8'h00, 8'h0F, 8'hF0, 4'd4},
        '{3'd2, 7'd5,  8'h0F, 8'h00, 8'h3C, 4'd6},
        '{3'd0, 7'd6,  8'h20, 8'hF0, 8'h10, 4'd5},
        '{3'd0, 7'd7,  8'h20, 8'h10, 8'hF0, 4'd5},
        '{3'd3, 7'd8,  8'h90, 8'h10, 8'h10, 4'd6},
        '{3'd5, 7'd9,  8'h0F, 8'h3C, 8'h30, 4'd7},
        '{3'd6, 7'd10, 8'h02, 8'h21, 8'h18, 4'd7},
        '{3'd7, 7'd11, 8'hFF, 8'hAA, 8'h55, 4'd8},
        '{3'd0, 7'd12, 8'h3C, 8'hF0, 8'hCF, 4'd4},
        '{3'd0, 7'd13, 8'h0C, 8'hF0, 8'h03, 4'd4},
        '{3'd0, 7'd14, 8'h3C, 8'hF0, 8'h33, 4'd4},
        '{3'd0, 7'd15, 8'h0F, 8'hFF, 8'hF0, 4'd4},
        '{3'd0, 7'd16, 8'hFF, 8'h0F, 8'hF0, 4'd4},
        '{3'd0, 7'd17, 8'h0F, 8'h00, 8'hF0, 4'd4},
        '{3'd0, 7'd18, 8'h0F, 8'hFF, 8'h0F, 4'd4},
        '{3'd0, 7'd80, 8'h11, 8'h77, 8'h77, 4'd9},
        '{3'd4, 7'd127,8'h11, 8'h81, 8'h02, 4'd9}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] addr, input logic [9:0] data);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_addr = addr;
        cfg_data = data;
        @(negedge clk);
        cfg_we   = 1'b0;
        cfg_data = '0;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [7:0] hist [32];
        wait_neg(3);
        check("R10 reset output", pix_out, 8'h00);
        rst = 1'b0;

        // R10: defaults give pass A with one-clock delay
        pix_in = 8'h3C;
        wait_neg(2);
        check("R10 default pass A latency 2", pix_out, 8'h3C);

        // R3 R4 R5 R6 R7 R8 R9: table walk
        for (int v = 0; v < NV; v++) begin
            cfg_write(2'd1, {2'b00, VEC[v].b});
            cfg_write(2'd0, {VEC[v].sh, VEC[v].op});
            pix_in = VEC[v].a;
            wait_neg(3);
            check($sformatf("R%0d R3 vector %0d", VEC[v].req, v), pix_out, VEC[v].exp);
        end

        // R2: writes with cfg_we low are ignored
        cfg_write(2'd0, {3'd0, 7'd3});
        cfg_write(2'd1, 10'h05A);
        wait_neg(2);
        check("R2 pass B after load", pix_out, 8'h5A);
        @(negedge clk);
        cfg_addr = 2'd1;
        cfg_data = 10'h0A5;
        wait_neg(2);
        cfg_addr = 2'd0;
        cfg_data = {3'd0, 7'd1};
        wait_neg(2);
        cfg_data = '0;
        wait_neg(1);
        check("R2 no write without enable", pix_out, 8'h5A);

        // R1: streaming latency for each delay code
        cfg_write(2'd0, 10'd0);
        for (int n = 1; n <= 4; n++) begin
            cfg_write(2'd2, 10'(n - 1));
            for (int j = 0; j < 16; j++) begin
                @(negedge clk);
                if (j >= n + 1)
                    check($sformatf("R1 delay %0d step %0d", n, j), pix_out, hist[j-n-1]);
                pix_in  = 8'(j * 13 + 1 + n * 40);
                hist[j] = pix_in;
            end
        end

        // R10: mid-run reset restores defaults
        cfg_write(2'd0, {3'd4, 7'd4});
        cfg_write(2'd1, 10'h0FF);
        cfg_write(2'd2, 10'd3);
        @(negedge clk);
        rst = 1'b1;
        wait_neg(2);
        check("R10 reset clears output", pix_out, 8'h00);
        rst    = 1'b0;
        pix_in = 8'h96;
        wait_neg(2);
        check("R10 after reset pass A delay 1", pix_out, 8'h96);
        cfg_write(2'd0, {3'd0, 7'd3});
        wait_neg(1);
        check("R10 constant cleared", pix_out, 8'h00);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule